// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup and Oldest-First Select

This block holds instructions that have been dispatched but not yet sent to execution. Each cycle it accepts a bundle of up to `WIDTH` instructions. Every instruction carries its own tag, an operation class and two source tags, and each source tag has a flag that says whether the source still waits on a producer. The bundle is placed into free queue slots. Among the entries whose sources are both resolved, the block sends the `WIDTH` oldest to execution in the same cycle. Age is decided by dispatch order and not by slot position.

Issued instructions pass through a fixed-latency pipeline chosen by their operation class. When an instruction leaves that pipeline, the block places its tag on a completion port. Every completion tag in a cycle is compared against the pending sources in the queue, and also against the bundle being dispatched in that cycle, so a consumer never misses its producer. The completion ports are outputs as well, so stages before dispatch can apply the same wakeup. Operand values are not carried.

Top module: `iq_wakeup_select`

## Requirements
- R1: `disp_stall` is high in a cycle exactly when the number of set `disp_valid` bits is greater than the number of free slots at the start of that cycle. While it is high, no lane of the bundle enters the queue, and none of them is ever issued.
- R2: A valid, unstalled lane enters the queue at the clock edge that ends its dispatch cycle. If both of its wait flags are 0, it issues in the next cycle.
- R3: An entry issues only when neither source still waits. A consumer of a completion broadcast in cycle t issues no earlier than cycle t+1.
- R4: Each cycle at most `WIDTH` ready entries issue, always the oldest by dispatch order regardless of slot index. Lane 0 is placed before lane 1 within a bundle. The oldest issued entry appears on issue lane 0, the next on lane 1, and so on, with no gaps.
- R5: Operation code 0 completes 1 cycle after its issue cycle, code 1 after 2 cycles and code 2 after 5 cycles. The completion appears on port index `code*WIDTH + issue_lane`, with its tag in the matching `TAG_W` slice of `cmp_tag`.
- R6: Each completion clears every queued source whose tag equals it. Several completions in one cycle act together. A source whose tag is not broadcast stays waiting.
- R7: A completion in the same cycle that an instruction is dispatched clears that instruction's matching sources.
- R8: A wait flag of 0 marks a source as resolved (no register, or a value already available), and its tag is then ignored.
- R9: Every issued instruction produces exactly one completion.
- R10: During reset, `iss_valid` and `cmp_valid` are all zero, and `disp_stall` is low when no lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | WIDTH | Lane holds an instruction |
| disp_op | input | 2*WIDTH | Operation class per lane |
| disp_tag | input | TAG_W*WIDTH | Instruction's own tag per lane |
| disp_src_a | input | TAG_W*WIDTH | First source tag per lane |
| disp_src_b | input | TAG_W*WIDTH | Second source tag per lane |
| disp_wait_a | input | WIDTH | First source still waits on a producer |
| disp_wait_b | input | WIDTH | Second source still waits on a producer |
| disp_stall | output | 1 | Bundle refused this cycle |
| iss_valid | output | WIDTH | Issue lane carries an instruction |
| iss_tag | output | TAG_W*WIDTH | Tag of issued instruction per lane |
| iss_op | output | 2*WIDTH | Operation class per issue lane |
| cmp_valid | output | 3*WIDTH | Completion per class and lane |
| cmp_tag | output | 3*TAG_W*WIDTH | Completing tag per port |

## Verification
Two coincidences are provoked on purpose. In the first, a completion lands in the very cycle a consumer of it is dispatched. The bench arranges this by dispatching the consumer exactly L cycles after its producer issues, and then requires the consumer to issue in the cycle after the broadcast, alongside an older consumer that was already waiting. In the second, a 5-cycle and a 1-cycle instruction complete in the same cycle on different ports. One consumer waits on both tags, and it must issue in the next cycle, while an entry waiting on a tag that is never broadcast must stay in the queue. A third stress fills the queue so that an older entry sits in a higher slot than a younger one, and the issue order and lanes then show whether selection follows age.

// File: rtl/iq_pkg.sv
package iq_pkg;
   localparam int NUM_OPS = 3;
   localparam int OP_W    = 2;

   function automatic int op_latency(input int op);
      case (op)
         0:       return 1;
         1:       return 2;
         default: return 5;
      endcase
   endfunction
endpackage

// File: rtl/iq_alloc.sv
module iq_alloc #(
   parameter int IQ_SIZE = 8,
   parameter int WIDTH   = 2,
   localparam int LANE_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [IQ_SIZE-1:0]             busy,
   input  logic [WIDTH-1:0]               req,
   output logic                           stall,
   output logic [IQ_SIZE-1:0]             wr_en,
   output logic [IQ_SIZE-1:0][LANE_W-1:0] wr_lane
);
   localparam int CNT_W = $clog2(IQ_SIZE + WIDTH + 1);

   logic [CNT_W-1:0]            n_req, n_free, fidx;
   logic [WIDTH-1:0][CNT_W-1:0] ord;

   always_comb begin
      n_req = '0;
      for (int d = 0; d < WIDTH; d++) begin
         ord[d] = n_req;
         n_req  = n_req + CNT_W'(req[d]);
      end
      n_free = '0;
      for (int s = 0; s < IQ_SIZE; s++) n_free = n_free + CNT_W'(!busy[s]);
      stall   = n_req > n_free;
      fidx    = '0;
      wr_en   = '0;
      wr_lane = '0;
      for (int s = 0; s < IQ_SIZE; s++) begin
         if (!busy[s]) begin
            for (int d = 0; d < WIDTH; d++) begin
               if (!stall && req[d] && ord[d] == fidx) begin
                  wr_en[s]   = 1'b1;
                  wr_lane[s] = LANE_W'(d);
               end
            end
            fidx = fidx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
   parameter int IQ_SIZE = 8,
   parameter int WIDTH   = 2,
   localparam int LANE_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [IQ_SIZE-1:0]              elig,
   input  logic [IQ_SIZE-1:0][IQ_SIZE-1:0] older,
   output logic [IQ_SIZE-1:0]              grant,
   output logic [IQ_SIZE-1:0][LANE_W-1:0]  grant_lane
);
   localparam int RANK_W = $clog2(IQ_SIZE + 1);

   for (genvar i = 0; i < IQ_SIZE; i++) begin : g_ent
      logic [RANK_W-1:0] rank;
      assign rank          = RANK_W'($countones(elig & older[i]));
      assign grant[i]      = elig[i] && (rank < RANK_W'(WIDTH));
      assign grant_lane[i] = LANE_W'(rank);
   end
endmodule

// File: rtl/iq_exec_pipe.sv
module iq_exec_pipe #(
   parameter int WIDTH = 2,
   parameter int TAG_W = 6,
   parameter int LAT   = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIDTH-1:0]       in_valid,
   input  logic [WIDTH*TAG_W-1:0] in_tag,
   output logic [WIDTH-1:0]       out_valid,
   output logic [WIDTH*TAG_W-1:0] out_tag
);
   logic [LAT-1:0][WIDTH-1:0]       stg_v;
   logic [LAT-1:0][WIDTH*TAG_W-1:0] stg_t;

   if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_v <= '0;
            stg_t <= '0;
         end else begin
            stg_v[0] <= in_valid;
            stg_t[0] <= in_tag;
         end
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_v <= '0;
            stg_t <= '0;
         end else begin
            stg_v <= {stg_v[LAT-2:0], in_valid};
            stg_t <= {stg_t[LAT-2:0], in_tag};
         end
      end
   end

   assign out_valid = stg_v[LAT-1];
   assign out_tag   = stg_t[LAT-1];
endmodule

// File: rtl/iq_wakeup_select.sv
module iq_wakeup_select import iq_pkg::*; #(
   parameter int IQ_SIZE = 8,
   parameter int WIDTH   = 2,
   parameter int TAG_W   = 6,
   localparam int NCMP   = NUM_OPS * WIDTH
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIDTH-1:0]       disp_valid,
   input  logic [WIDTH*OP_W-1:0]  disp_op,
   input  logic [WIDTH*TAG_W-1:0] disp_tag,
   input  logic [WIDTH*TAG_W-1:0] disp_src_a,
   input  logic [WIDTH*TAG_W-1:0] disp_src_b,
   input  logic [WIDTH-1:0]       disp_wait_a,
   input  logic [WIDTH-1:0]       disp_wait_b,
   output logic                   disp_stall,
   output logic [WIDTH-1:0]       iss_valid,
   output logic [WIDTH*TAG_W-1:0] iss_tag,
   output logic [WIDTH*OP_W-1:0]  iss_op,
   output logic [NCMP-1:0]        cmp_valid,
   output logic [NCMP*TAG_W-1:0]  cmp_tag
);
   localparam int LANE_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   if (WIDTH < 1 || WIDTH > IQ_SIZE) begin : g_bad_width
      $error("iq_wakeup_select: WIDTH must lie in 1..IQ_SIZE");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("iq_wakeup_select: TAG_W must be positive");
   end

   logic [IQ_SIZE-1:0]              valid_q, wait_a_q, wait_b_q;
   logic [IQ_SIZE-1:0][OP_W-1:0]    op_q;
   logic [IQ_SIZE-1:0][TAG_W-1:0]   tag_q, src_a_q, src_b_q;
   logic [IQ_SIZE-1:0][IQ_SIZE-1:0] older_q;

   logic [IQ_SIZE-1:0]             wr_en, grant, elig;
   logic [IQ_SIZE-1:0][LANE_W-1:0] wr_lane, grant_lane;
   logic [IQ_SIZE-1:0]             hit_a, hit_b;
   logic [WIDTH-1:0]               dhit_a, dhit_b;

   iq_alloc #(.IQ_SIZE(IQ_SIZE), .WIDTH(WIDTH)) u_alloc (
      .busy    (valid_q),
      .req     (disp_valid),
      .stall   (disp_stall),
      .wr_en   (wr_en),
      .wr_lane (wr_lane)
   );

   assign elig = valid_q & ~wait_a_q & ~wait_b_q;

   iq_select #(.IQ_SIZE(IQ_SIZE), .WIDTH(WIDTH)) u_select (
      .elig       (elig),
      .older      (older_q),
      .grant      (grant),
      .grant_lane (grant_lane)
   );

   // Tag match of every completion port against queued and incoming sources
   always_comb begin
      hit_a  = '0;
      hit_b  = '0;
      dhit_a = '0;
      dhit_b = '0;
      for (int c = 0; c < NCMP; c++) begin
         if (cmp_valid[c]) begin
            for (int i = 0; i < IQ_SIZE; i++) begin
               if (src_a_q[i] == cmp_tag[c*TAG_W +: TAG_W]) hit_a[i] = 1'b1;
               if (src_b_q[i] == cmp_tag[c*TAG_W +: TAG_W]) hit_b[i] = 1'b1;
            end
            for (int d = 0; d < WIDTH; d++) begin
               if (disp_src_a[d*TAG_W +: TAG_W] == cmp_tag[c*TAG_W +: TAG_W]) dhit_a[d] = 1'b1;
               if (disp_src_b[d*TAG_W +: TAG_W] == cmp_tag[c*TAG_W +: TAG_W]) dhit_b[d] = 1'b1;
            end
         end
      end
   end

   // Issue bundle: the granted entry of rank w drives lane w
   always_comb begin
      iss_valid = '0;
      iss_tag   = '0;
      iss_op    = '0;
      for (int w = 0; w < WIDTH; w++) begin
         for (int i = 0; i < IQ_SIZE; i++) begin
            if (grant[i] && grant_lane[i] == LANE_W'(w)) begin
               iss_valid[w]               = 1'b1;
               iss_tag[w*TAG_W +: TAG_W]  = tag_q[i];
               iss_op[w*OP_W +: OP_W]     = op_q[i];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= '0;
         wait_a_q <= '0;
         wait_b_q <= '0;
         op_q     <= '0;
         tag_q    <= '0;
         src_a_q  <= '0;
         src_b_q  <= '0;
         older_q  <= '0;
      end else begin
         for (int i = 0; i < IQ_SIZE; i++) begin
            if (wr_en[i]) begin
               valid_q[i]  <= 1'b1;
               op_q[i]     <= disp_op[wr_lane[i]*OP_W +: OP_W];
               tag_q[i]    <= disp_tag[wr_lane[i]*TAG_W +: TAG_W];
               src_a_q[i]  <= disp_src_a[wr_lane[i]*TAG_W +: TAG_W];
               src_b_q[i]  <= disp_src_b[wr_lane[i]*TAG_W +: TAG_W];
               wait_a_q[i] <= disp_wait_a[wr_lane[i]] && !dhit_a[wr_lane[i]];
               wait_b_q[i] <= disp_wait_b[wr_lane[i]] && !dhit_b[wr_lane[i]];
            end else begin
               if (grant[i]) valid_q[i] <= 1'b0;
               wait_a_q[i] <= wait_a_q[i] && !hit_a[i];
               wait_b_q[i] <= wait_b_q[i] && !hit_b[i];
            end
            // Age matrix: older_q[i][j] means entry j was dispatched before entry i
            for (int j = 0; j < IQ_SIZE; j++) begin
               if (wr_en[i])
                  older_q[i][j] <= (valid_q[j] && !grant[j]) ||
                                   (wr_en[j] && wr_lane[j] < wr_lane[i]);
               else if (wr_en[j])
                  older_q[i][j] <= 1'b0;
            end
         end
      end
   end

   for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
      logic [WIDTH-1:0] ex_v;
      always_comb begin
         for (int w = 0; w < WIDTH; w++)
            ex_v[w] = iss_valid[w] && (iss_op[w*OP_W +: OP_W] == OP_W'(k));
      end
      iq_exec_pipe #(.WIDTH(WIDTH), .TAG_W(TAG_W), .LAT(op_latency(k))) u_pipe (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (ex_v),
         .in_tag    (iss_tag),
         .out_valid (cmp_valid[k*WIDTH +: WIDTH]),
         .out_tag   (cmp_tag[k*WIDTH*TAG_W +: WIDTH*TAG_W])
      );
   end
endmodule

// File: rtl/iq_wakeup_select_chk.sv
module iq_wakeup_select_chk import iq_pkg::*; #(
   parameter int IQ_SIZE = 8,
   parameter int WIDTH   = 2,
   parameter int TAG_W   = 6,
   localparam int NCMP   = NUM_OPS * WIDTH
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [WIDTH-1:0]              disp_valid,
   input logic [WIDTH*OP_W-1:0]         disp_op,
   input logic                          disp_stall,
   input logic [WIDTH-1:0]              iss_valid,
   input logic [WIDTH*TAG_W-1:0]        iss_tag,
   input logic [WIDTH*OP_W-1:0]         iss_op,
   input logic [NCMP-1:0]               cmp_valid,
   input logic [NCMP*TAG_W-1:0]         cmp_tag,
   input logic [IQ_SIZE-1:0]            valid_q,
   input logic [IQ_SIZE-1:0]            wait_a_q,
   input logic [IQ_SIZE-1:0]            wait_b_q,
   input logic [IQ_SIZE-1:0][TAG_W-1:0] src_a_q,
   input logic [IQ_SIZE-1:0]            grant
);
   logic [IQ_SIZE-1:0] seen_a;

   always_comb begin
      seen_a = '0;
      for (int c = 0; c < NCMP; c++)
         for (int i = 0; i < IQ_SIZE; i++)
            if (cmp_valid[c] && cmp_tag[c*TAG_W +: TAG_W] == src_a_q[i]) seen_a[i] = 1'b1;
   end

   p_stall_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stall |-> ($countones(valid_q) + $countones(disp_valid)) > IQ_SIZE);

   p_no_fill_on_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stall |=> $countones(valid_q) <= $past($countones(valid_q)));

   p_op_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid[0] && !disp_stall) |-> disp_op[OP_W-1:0] < OP_W'(NUM_OPS));

   p_full_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(valid_q & ~wait_a_q & ~wait_b_q & ~grant)) |-> $countones(iss_valid) == WIDTH);

   p_lat_op0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[0] && iss_op[OP_W-1:0] == 2'd0) |=>
         (cmp_valid[0] && cmp_tag[TAG_W-1:0] == $past(iss_tag[TAG_W-1:0])));

   p_lat_op1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[0] && iss_op[OP_W-1:0] == 2'd1) |=> ##1
         (cmp_valid[WIDTH] && cmp_tag[WIDTH*TAG_W +: TAG_W] == $past(iss_tag[TAG_W-1:0], 2)));

   p_lat_op2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[0] && iss_op[OP_W-1:0] == 2'd2) |=> ##4
         (cmp_valid[2*WIDTH] && cmp_tag[2*WIDTH*TAG_W +: TAG_W] == $past(iss_tag[TAG_W-1:0], 5)));

   for (genvar w = 1; w < WIDTH; w++) begin : g_lane
      p_lane_packed_r4: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[w] |-> iss_valid[w-1]);
   end

   for (genvar i = 0; i < IQ_SIZE; i++) begin : g_ent
      p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |-> (valid_q[i] && !wait_a_q[i] && !wait_b_q[i]));
      p_wake_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_q[i] && wait_a_q[i] && seen_a[i]) |=> !wait_a_q[i]);
   end
endmodule

bind iq_wakeup_select iq_wakeup_select_chk #(
   .IQ_SIZE(IQ_SIZE), .WIDTH(WIDTH), .TAG_W(TAG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_valid (disp_valid),
   .disp_op    (disp_op),
   .disp_stall (disp_stall),
   .iss_valid  (iss_valid),
   .iss_tag    (iss_tag),
   .iss_op     (iss_op),
   .cmp_valid  (cmp_valid),
   .cmp_tag    (cmp_tag),
   .valid_q    (valid_q),
   .wait_a_q   (wait_a_q),
   .wait_b_q   (wait_b_q),
   .src_a_q    (src_a_q),
   .grant      (grant)
);

// File: tb/iq_wakeup_select_bench.sv
`timescale 1ns/1ps
module iq_wakeup_select_bench;
   localparam int IQ = 4;
   localparam int W  = 2;
   localparam int TW = 4;
   localparam int NC = 3 * W;
   localparam int NT = 1 << TW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0]    disp_valid = '0;
   logic [W*2-1:0]  disp_op = '0;
   logic [W*TW-1:0] disp_tag = '0, disp_src_a = '0, disp_src_b = '0;
   logic [W-1:0]    disp_wait_a = '0, disp_wait_b = '0;
   logic            disp_stall;
   logic [W-1:0]    iss_valid;
   logic [W*TW-1:0] iss_tag;
   logic [W*2-1:0]  iss_op;
   logic [NC-1:0]   cmp_valid;
   logic [NC*TW-1:0] cmp_tag;

   iq_wakeup_select #(.IQ_SIZE(IQ), .WIDTH(W), .TAG_W(TW)) u_iq_wakeup_select (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_op(disp_op), .disp_tag(disp_tag),
      .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
      .disp_wait_a(disp_wait_a), .disp_wait_b(disp_wait_b),
      .disp_stall(disp_stall),
      .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int tests = 0, fails = 0;
   int iss_cyc[NT], iss_lane[NT], iss_cnt[NT];
   int cmp_cyc[NT], cmp_port[NT], cmp_cnt[NT];

   // Event log taken away from the clock edge
   initial forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         for (int w = 0; w < W; w++)
            if (iss_valid[w]) begin
               iss_cyc[iss_tag[w*TW +: TW]]  = cyc;
               iss_lane[iss_tag[w*TW +: TW]] = w;
               iss_cnt[iss_tag[w*TW +: TW]]++;
            end
         for (int p = 0; p < NC; p++)
            if (cmp_valid[p]) begin
               cmp_cyc[cmp_tag[p*TW +: TW]]  = cyc;
               cmp_port[cmp_tag[p*TW +: TW]] = p;
               cmp_cnt[cmp_tag[p*TW +: TW]]++;
            end
      end
   end

   task automatic clear_log();
      for (int t = 0; t < NT; t++) begin
         iss_cyc[t] = -1; iss_lane[t] = -1; iss_cnt[t] = 0;
         cmp_cyc[t] = -1; cmp_port[t] = -1; cmp_cnt[t] = 0;
      end
   endtask

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(negedge clk);
      disp_valid = '0; disp_op = '0; disp_tag = '0;
      disp_src_a = '0; disp_src_b = '0; disp_wait_a = '0; disp_wait_b = '0;
   endtask

   task automatic put(input int lane, input int tag, input int op,
                      input bit wa, input int sa, input bit wb, input int sb);
      disp_valid[lane]        = 1'b1;
      disp_op[lane*2 +: 2]    = 2'(op);
      disp_tag[lane*TW +: TW] = TW'(tag);
      disp_src_a[lane*TW +: TW] = TW'(sa);
      disp_src_b[lane*TW +: TW] = TW'(sb);
      disp_wait_a[lane]       = wa;
      disp_wait_b[lane]       = wb;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) next_cycle();
   endtask

   function automatic int lat_of(input int op);
      return (op == 0) ? 1 : (op == 1) ? 2 : 5;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int d, L;
      clear_log();
      // R10: quiet outputs during reset
      repeat (3) @(negedge clk);
      #0.5;
      check_eq("R10", "stall in reset", int'(disp_stall), 0);
      check_eq("R10", "iss_valid in reset", int'(iss_valid), 0);
      check_eq("R10", "cmp_valid in reset", int'(cmp_valid), 0);
      rst_n = 1'b1;
      idle(2);

      // R2 R5 R8 R9: lone independent instruction of each class
      for (int op = 0; op < 3; op++) begin
         clear_log();
         next_cycle();
         put(op % 2, op + 1, op, 1'b0, 7, 1'b0, 9);   // R8: tags 7/9 ignored
         d = cyc;
         idle(9);
         check_eq("R2", "issue cycle", iss_cyc[op+1], d + 1);
         check_eq("R4", "issue lane", iss_lane[op+1], 0);
         check_eq("R5", "completion cycle", cmp_cyc[op+1], d + 1 + lat_of(op));
         check_eq("R5", "completion port", cmp_port[op+1], op * W);
         check_eq("R9", "completion count", cmp_cnt[op+1], 1);
      end

      // R3 R7: consumer waiting in queue and consumer dispatched with the broadcast
      for (int k = 0; k < 3; k++) begin
         clear_log();
         next_cycle();
         put(0, 1, k, 1'b0, 0, 1'b0, 0);
         d = cyc;
         L = lat_of(k);
         for (int n = 0; n <= L; n++) begin
            next_cycle();
            if (n == 0) put(0, 2, 0, 1'b1, 1, 1'b0, 0);
            if (n == L) put(1, 3, 0, 1'b0, 0, 1'b1, 1);
         end
         idle(6);
         check_eq("R3", "waiting consumer issue", iss_cyc[2], d + 2 + L);
         check_eq("R7", "same-cycle consumer issue", iss_cyc[3], d + 2 + L);
         check_eq("R4", "older consumer lane", iss_lane[2], 0);
         check_eq("R4", "younger consumer lane", iss_lane[3], 1);
      end

      // R1 R4: older entries in higher slots, full queue stall
      clear_log();
      next_cycle();
      put(0, 0, 2, 1'b0, 0, 1'b0, 0);                 // producer P, slot 0
      d = cyc;
      next_cycle();
      put(0, 1, 0, 1'b1, 0, 1'b0, 0);                 // Y1 slot 1
      put(1, 2, 1, 1'b0, 0, 1'b1, 0);                 // Y2 slot 2
      next_cycle();
      put(0, 3, 0, 1'b1, 0, 1'b0, 0);                 // Z slot 0 (youngest)
      next_cycle();
      put(0, 4, 0, 1'b0, 0, 1'b0, 0);
      put(1, 5, 0, 1'b0, 0, 1'b0, 0);
      #0.5;
      check_eq("R1", "stall with 1 free, 2 requested", int'(disp_stall), 1);
      next_cycle();
      put(1, 6, 0, 1'b0, 0, 1'b0, 0);
      #0.5;
      check_eq("R1", "no stall with 1 free, 1 requested", int'(disp_stall), 0);
      idle(8);
      check_eq("R1", "stalled lane 0 never issued", iss_cnt[4], 0);
      check_eq("R1", "stalled lane 1 never issued", iss_cnt[5], 0);
      check_eq("R2", "lane 1 alone issue", iss_cyc[6], d + 5);
      check_eq("R5", "producer completion", cmp_cyc[0], d + 6);
      check_eq("R4", "Y1 issue", iss_cyc[1], d + 7);
      check_eq("R4", "Y2 issue", iss_cyc[2], d + 7);
      check_eq("R4", "Y1 lane", iss_lane[1], 0);
      check_eq("R4", "Y2 lane", iss_lane[2], 1);
      check_eq("R4", "Z issue after older pair", iss_cyc[3], d + 8);
      check_eq("R5", "class 1 lane 1 port", cmp_port[2], 1 * W + 1);
      check_eq("R5", "class 1 lane 1 cycle", cmp_cyc[2], d + 9);

      // R6: two completions in one cycle, plus an unmatched waiter
      clear_log();
      next_cycle();
      put(0, 1, 2, 1'b0, 0, 1'b0, 0);                 // A: 5-cycle
      d = cyc;
      next_cycle();
      put(0, 3, 0, 1'b1, 1, 1'b1, 2);                 // C waits on A and B
      idle(2);
      next_cycle();
      put(1, 2, 0, 1'b0, 0, 1'b0, 0);                 // B: 1-cycle
      put(0, 5, 0, 1'b1, 7, 1'b0, 0);                 // E waits on tag never sent
      idle(8);
      check_eq("R6", "A completion", cmp_cyc[1], d + 6);
      check_eq("R6", "B completion", cmp_cyc[2], d + 6);
      check_eq("R6", "C issue after dual wakeup", iss_cyc[3], d + 7);
      check_eq("R6", "unmatched waiter stays", iss_cnt[5], 0);
      check_eq("R9", "C completion count", cmp_cnt[3], 1);
      check_eq("R9", "A completion count", cmp_cnt[1], 1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule